// File: doc/BRIEF.md
# Same-Line Address Reuse Detector

This unit forms an effective address by adding a sign-extended 16-bit displacement to a 32-bit base register value. Along with the sum, it reports whether the new address falls in the same cache line as the base, and whether it falls in the same virtual page. A memory pipeline uses these flags to decide whether translation and tag-match results already held for the base register can be reused. If so, the translation lookup and the tag check for the derived address can be skipped.

The unit never compares the old and new upper address bits. The adder is split at the line-offset and page-offset boundaries, and each locality flag is taken from three things: the carry that crosses that boundary, the sign of the displacement, and a check that the displacement's bits above the boundary are pure sign extension. A positive displacement keeps locality when no carry crosses. A negative displacement keeps locality when a carry does cross, because that carry cancels the all-ones upper half. All results are registered one cycle after the input strobe, and an output valid signal comes with them.

Top module: `addr_reuse_detect`

## Requirements
- R1: One cycle after a clock edge that samples `in_valid` high, `out_sum` equals `in_base` plus the sign-extended `in_imm`, modulo 2^32.
- R2: `out_valid` is high in the cycle after an edge that sampled `in_valid` high, and low in the cycle after an edge that sampled it low.
- R3: `out_same_line` is high exactly when bits [31:5] of `out_sum` equal bits [31:5] of the sampled base. The line offset is 5 bits by default and is set by parameter `LINE_W`.
- R4: `out_same_page` is high exactly when bits [31:13] of `out_sum` equal bits [31:13] of the sampled base. The page size is 8 KB, so the page offset is 13 bits (`PAGE_W`).
- R5: A non-negative displacement whose addition carries into bit 5 (or into bit 13) clears `out_same_line` (or `out_same_page`).
- R6: A negative displacement (bit 15 of `in_imm` set) whose addition produces no carry into bit 5 clears `out_same_line`. When the addition does carry into bit 5 and the displacement fits within the line offset, `out_same_line` is set.
- R7: A displacement of zero always gives `out_same_line` = 1 and `out_same_page` = 1.
- R8: While `in_valid` is low, `out_sum`, `out_same_line` and `out_same_page` keep their previous values.
- R9: `in_imm` is two's complement. Bit 15 is copied into bits [31:16] before the add, so 16'hFFFF adds -1 and 16'h8000 adds -32768.
- R10: Whenever `out_same_line` is high, `out_same_page` is also high.
- R11: While `rst_n` is low, `out_valid`, `out_sum`, `out_same_line` and `out_same_page` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_base | input | 32 | Base register value |
| in_imm | input | 16 | Two's-complement displacement |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_sum | output | 32 | Registered effective address |
| out_same_line | output | 1 | Sum lies in the base's cache line |
| out_same_page | output | 1 | Sum lies in the base's virtual page |

## Verification
Every result (sum, both flags and output valid) appears exactly one clock edge after the edge that samples the strobe. Nothing in the unit has a longer latency. The bench drives operands on the falling edge and keeps one pending record of the last vector it drove. At the next falling edge, after the capturing rising edge has settled, it compares the outputs against that record. This gives back-to-back vectors with a fixed one-cycle check offset. For the hold behaviour, the bench drops the strobe and changes the operands, then compares the outputs over several falling edges against the last captured values.

// File: rtl/addr_reuse_pkg.sv
package addr_reuse_pkg;

   // Locality result for one derived address
   typedef struct packed {
      logic same_line;
      logic same_page;
   } locality_t;

   // Segment boundaries of the split adder: 0, line, page, top
   function automatic int seg_bound(input int k, input int line_w,
                                    input int page_w, input int addr_w);
      case (k)
         0:       return 0;
         1:       return line_w;
         2:       return page_w;
         default: return addr_w;
      endcase
   endfunction

endpackage

// File: rtl/ar_sext.sv
module ar_sext #(
   parameter int IMM_W  = 16,
   parameter int ADDR_W = 32
) (
   input  logic [IMM_W-1:0]  imm,
   output logic [ADDR_W-1:0] imm_ext
);
   localparam int EXT_W = ADDR_W - IMM_W;

   generate
      if (EXT_W == 0) begin : g_same_width
         assign imm_ext = imm;
      end else begin : g_extend
         assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
      end
   endgenerate

   initial begin
      sext_width_chk: assert (ADDR_W >= IMM_W)
         else $error("ar_sext: ADDR_W must not be below IMM_W");
   end
endmodule

// File: rtl/ar_add_seg.sv
module ar_add_seg #(
   parameter int SEG_W = 5
) (
   input  logic [SEG_W-1:0] a,
   input  logic [SEG_W-1:0] b,
   input  logic             cin,
   output logic [SEG_W-1:0] sum,
   output logic             cout
);
   logic [SEG_W:0] wide;

   assign wide = {1'b0, a} + {1'b0, b} + {{SEG_W{1'b0}}, cin};
   assign sum  = wide[SEG_W-1:0];
   assign cout = wide[SEG_W];

   initial begin
      seg_width_chk: assert (SEG_W >= 1)
         else $error("ar_add_seg: SEG_W must be positive");
   end
endmodule

// File: rtl/ar_seg_adder.sv
module ar_seg_adder
   import addr_reuse_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LINE_W = 5,
   parameter int PAGE_W = 13
) (
   input  logic [ADDR_W-1:0] a,
   input  logic [ADDR_W-1:0] b,
   output logic [ADDR_W-1:0] sum,
   output logic              carry_line,
   output logic              carry_page
);
   localparam int NSEG = 3;

   // carry[k] enters segment k
   logic [NSEG-1:0] carry;

   assign carry[0] = 1'b0;

   generate
      for (genvar k = 0; k < NSEG; k++) begin : g_seg
         localparam int LO = seg_bound(k, LINE_W, PAGE_W, ADDR_W);
         localparam int HI = seg_bound(k + 1, LINE_W, PAGE_W, ADDR_W);
         localparam int SW = HI - LO;
         if (k < NSEG - 1) begin : g_mid
            ar_add_seg #(.SEG_W(SW)) u_seg (
               .a    (a[HI-1:LO]),
               .b    (b[HI-1:LO]),
               .cin  (carry[k]),
               .sum  (sum[HI-1:LO]),
               .cout (carry[k+1])
            );
         end else begin : g_top
            // Top segment: its carry out is discarded
            assign sum[HI-1:LO] = a[HI-1:LO] + b[HI-1:LO] + {{(SW-1){1'b0}}, carry[k]};
         end
      end
   endgenerate

   assign carry_line = carry[1];
   assign carry_page = carry[2];

   initial begin
      seg_order_chk: assert (LINE_W >= 1 && PAGE_W > LINE_W && ADDR_W > PAGE_W + 1)
         else $error("ar_seg_adder: need 0 < LINE_W < PAGE_W < ADDR_W-1");
   end
endmodule

// File: rtl/ar_locality.sv
module ar_locality #(
   parameter int IMM_W   = 16,
   parameter int FIELD_W = 5
) (
   input  logic [IMM_W-1:0] imm,
   input  logic             carry,
   output logic             same
);
   logic sign;
   logic fits;

   assign sign = imm[IMM_W-1];

   generate
      if (FIELD_W >= IMM_W - 1) begin : g_always_fits
         // All displacement bits above the field are sign copies
         assign fits = 1'b1;
      end else begin : g_check_fit
         logic [IMM_W-FIELD_W-1:0] upper;
         assign upper = imm[IMM_W-1:FIELD_W];
         assign fits  = (&upper) | ~(|upper);
      end
   endgenerate

   // Non-negative: no carry keeps locality; negative: carry cancels the
   // all-ones upper half and keeps locality.
   assign same = fits & (sign ? carry : ~carry);

   // R7
   always_comb begin
      if (imm == '0) begin
         zero_imm_chk: assert (same);
      end
   end

   initial begin
      field_width_chk: assert (FIELD_W >= 1)
         else $error("ar_locality: FIELD_W must be positive");
   end
endmodule

// File: rtl/addr_reuse_detect.sv
module addr_reuse_detect
   import addr_reuse_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16,
   parameter int LINE_W = 5,
   parameter int PAGE_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [ADDR_W-1:0] in_base,
   input  logic [IMM_W-1:0]  in_imm,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_sum,
   output logic              out_same_line,
   output logic              out_same_page
);
   localparam int LTAG_W = ADDR_W - LINE_W;
   localparam int PTAG_W = ADDR_W - PAGE_W;

   logic [ADDR_W-1:0] imm_ext;
   logic [ADDR_W-1:0] sum_d;
   logic              carry_line;
   logic              carry_page;
   locality_t         loc_d;
   locality_t         loc_q;
   logic              valid_q;
   logic [ADDR_W-1:0] sum_q;

   ar_sext #(.IMM_W(IMM_W), .ADDR_W(ADDR_W)) u_sext (
      .imm     (in_imm),
      .imm_ext (imm_ext)
   );

   ar_seg_adder #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .PAGE_W(PAGE_W)) u_add (
      .a          (in_base),
      .b          (imm_ext),
      .sum        (sum_d),
      .carry_line (carry_line),
      .carry_page (carry_page)
   );

   ar_locality #(.IMM_W(IMM_W), .FIELD_W(LINE_W)) u_line (
      .imm   (in_imm),
      .carry (carry_line),
      .same  (loc_d.same_line)
   );

   ar_locality #(.IMM_W(IMM_W), .FIELD_W(PAGE_W)) u_page (
      .imm   (in_imm),
      .carry (carry_page),
      .same  (loc_d.same_page)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         sum_q   <= '0;
         loc_q   <= '0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            sum_q <= sum_d;
            loc_q <= loc_d;
         end
      end
   end

   assign out_valid     = valid_q;
   assign out_sum       = sum_q;
   assign out_same_line = loc_q.same_line;
   assign out_same_page = loc_q.same_page;

   initial begin
      top_param_chk: assert (IMM_W >= 2 && ADDR_W >= IMM_W && LINE_W >= 1
                             && PAGE_W > LINE_W && ADDR_W > PAGE_W + 1)
         else $error("addr_reuse_detect: inconsistent field widths");
   end

   // R1
   sum_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_sum == $past(in_base) + ADDR_W'($signed($past(in_imm))));

   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R3
   line_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_same_line ==
         (out_sum[ADDR_W-1:LINE_W] == LTAG_W'($past(in_base[ADDR_W-1:LINE_W]))));

   // R4
   page_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_same_page ==
         (out_sum[ADDR_W-1:PAGE_W] == PTAG_W'($past(in_base[ADDR_W-1:PAGE_W]))));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_sum) && $stable(out_same_line) && $stable(out_same_page));

   // R10
   line_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_same_line |-> out_same_page);
endmodule

// File: tb/addr_reuse_detect_test.sv
module addr_reuse_detect_test;
   localparam int  LW  = 5;
   localparam int  PW  = 13;
   localparam time CLK = 4ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_base = '0;
   logic [15:0] in_imm = '0;
   logic        out_valid;
   logic [31:0] out_sum;
   logic        out_same_line;
   logic        out_same_page;

   int checks = 0;
   int errors = 0;

   logic        pend = 1'b0;
   logic [31:0] pend_base = '0;
   logic [15:0] pend_imm = '0;

   always #(CLK/2) clk = ~clk;

   addr_reuse_detect #(.ADDR_W(32), .IMM_W(16), .LINE_W(LW), .PAGE_W(PW)) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_base       (in_base),
      .in_imm        (in_imm),
      .out_valid     (out_valid),
      .out_sum       (out_sum),
      .out_same_line (out_same_line),
      .out_same_page (out_same_page)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h base=%h imm=%h",
                  tag, act, exp, pend_base, pend_imm);
      end
   endtask

   // Compare outputs against the pending vector captured at the last rising edge
   task automatic check_pending();
      logic [31:0] exp_sum;
      logic        exp_line;
      logic        exp_page;
      logic        cl;
      logic        cp;
      exp_sum  = pend_base + {{16{pend_imm[15]}}, pend_imm};
      exp_line = (exp_sum[31:LW] == pend_base[31:LW]);
      exp_page = (exp_sum[31:PW] == pend_base[31:PW]);
      cl = ({1'b0, pend_base[LW-1:0]} + {1'b0, pend_imm[LW-1:0]}) >> LW != 0;
      cp = ({1'b0, pend_base[PW-1:0]} + {1'b0, pend_imm[PW-1:0]}) >> PW != 0;
      chk("R2 out_valid", 32'(out_valid), 32'd1);
      if (pend_imm[15]) chk("R9 sum", out_sum, exp_sum);
      else              chk("R1 sum", out_sum, exp_sum);
      if (pend_imm == 16'h0) begin
         chk("R7 line", 32'(out_same_line), 32'd1);
         chk("R7 page", 32'(out_same_page), 32'd1);
      end else if (!pend_imm[15]) begin
         if (cl) chk("R5 line", 32'(out_same_line), 32'd0);
         else    chk("R3 line", 32'(out_same_line), 32'(exp_line));
         if (cp) chk("R5 page", 32'(out_same_page), 32'd0);
         else    chk("R4 page", 32'(out_same_page), 32'(exp_page));
      end else begin
         chk("R6 line", 32'(out_same_line), 32'(exp_line));
         if (!cl) chk("R6 no-carry line", 32'(out_same_line), 32'd0);
         chk("R4 page", 32'(out_same_page), 32'(exp_page));
      end
      if (out_same_line) chk("R10 page under line", 32'(out_same_page), 32'd1);
   endtask

   task automatic step(input logic v, input logic [31:0] b, input logic [15:0] i);
      @(negedge clk);
      if (pend) check_pending();
      in_valid  = v;
      in_base   = b;
      in_imm    = i;
      pend      = v;
      pend_base = b;
      pend_imm  = i;
   endtask

   initial begin
      #(CLK * 190000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] imm_set [9];
      logic [31:0] held_sum;
      logic        held_line;
      logic        held_page;
      imm_set = '{16'h0000, 16'h0001, 16'hFFFF, 16'h001F, 16'hFFE0,
                  16'h1FFF, 16'hE000, 16'h7FFF, 16'h8000};

      // R11: reset state
      repeat (3) @(negedge clk);
      chk("R11 valid", 32'(out_valid), 32'd0);
      chk("R11 sum", out_sum, 32'd0);
      chk("R11 line", 32'(out_same_line), 32'd0);
      chk("R11 page", 32'(out_same_page), 32'd0);
      rst_n = 1'b1;

      // Full displacement sweep next to a page boundary
      for (int k = 0; k < 65536; k++) step(1'b1, 32'h8000_1FF0, 16'(k));

      // Base offset sweep against boundary displacements
      for (int b = 0; b < 16384; b += 5) begin
         for (int j = 0; j < 9; j++) step(1'b1, 32'hC3A4_0000 | 32'(b), imm_set[j]);
      end

      // Random operands
      for (int n = 0; n < 3000; n++) step(1'b1, $urandom, 16'($urandom));

      // Wrap across the top of the address space (R1)
      step(1'b1, 32'hFFFF_FFF0, 16'h0020);
      step(1'b1, 32'h0000_0008, 16'hFFF0);

      // R8: strobe low, operands changing, outputs hold
      step(1'b1, 32'h1234_5678, 16'h0004);
      step(1'b0, 32'hDEAD_BEEF, 16'h4321);
      held_sum  = out_sum;
      held_line = out_same_line;
      held_page = out_same_page;
      for (int n = 0; n < 4; n++) begin
         @(negedge clk);
         chk("R2 idle valid", 32'(out_valid), 32'd0);
         chk("R8 hold sum", out_sum, held_sum);
         chk("R8 hold line", 32'(out_same_line), 32'(held_line));
         chk("R8 hold page", 32'(out_same_page), 32'(held_page));
         in_base = in_base + 32'h0000_1000;
         in_imm  = in_imm ^ 16'h8001;
      end
      chk("R1 held sum value", held_sum, 32'h1234_567C);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule